// File: doc/BRIEF.md
# Offset-Indexed Intermediate-Cell Restorer

This block rebuilds the exact contents of a 256-cell, two-bit-per-cell memory line. On write, cells holding 01 or 10 were programmed only to a single shared middle level. One correction bit per such cell was kept in a spare field of 32 three-level cells. On read, every data cell arrives as a two-bit symbol. A cell whose two bits differ is a "middle" cell. Its true value is chosen by a correction bit, and that bit's index is the number of middle cells to its left.

The spare field is unpacked first. Each pair of three-level spare cells becomes three correction bits, so the field yields 48 bits in all. The middle-cell count is then built in parallel for every position. A per-group total is taken first, and each cell's running position inside its group is added to it. Each middle cell whose count is below 48 is then rewritten. The block accepts one line per clock and returns it with a fixed delay, flagged by a valid output. A bypass input turns the whole correction off while the spare field is lent to permanent-fault repair.

Top module: `corr_offset_decoder`

## Requirements
- R1: After reset, valid_o and err_o are 0. A line presented with valid_i=1 at a rising edge appears on line_o with valid_o=1 exactly two rising edges later.
- R2: A data cell whose symbol is 00 or 11 leaves unchanged. Cell n is line_i[2n+1:2n], and cell 255 is the leftmost.
- R3: A cell with symbol 01 or 10 is a middle cell. Its offset is the count of middle cells among cells n+1 through 255. When the offset is below 48, the cell is rewritten from correction bit number offset: 01 if the bit is 0, and 10 if the bit is 1.
- R4: A middle cell whose offset is 48 or more passes through unchanged.
- R5: Spare cell j is spare_i[2j+1:2j]. Its symbol gives a level: 11 is level 0, 00 is level 2, and both 01 and 10 are level 1. Pair p (0..15) consists of spare cells 31-2p (digit a) and 30-2p (digit b), with value 3a+b. That value's three bits, most significant first, become correction bits 3p, 3p+1 and 3p+2.
- R6: A pair whose value is 8 (both cells at level 2) is invalid. Such a line is output unchanged, with err_o=1 alongside valid_o.
- R7: With bypass_i=1, the line is output unchanged and err_o stays 0, whatever the spare field holds.
- R8: Lines arriving on consecutive cycles are each processed independently, in order, with no gap required.
- R9: When valid_i is 0, two edges later valid_o and err_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Line on line_i/spare_i is valid |
| bypass_i | input | 1 | Disable all correction for this line |
| line_i | input | 512 | Sensed data cells, two bits each |
| spare_i | input | 64 | Sensed spare cells, two bits each |
| valid_o | output | 1 | line_o/err_o are valid |
| err_o | output | 1 | Spare field held an invalid pair |
| line_o | output | 512 | Restored line |

## Verification
Two functions can meet in the same line: the invalid-pair error and the bypass. Directed lines carry a spare pair of value 8 together with bypass_i=1, and there the bypass must win, with the line unchanged and err_o low. The same line is then sent again without bypass, so err_o must rise. The middle-cell boundary is also checked inside one line. An all-middle line puts offsets 47 and 48 next to each other, and the scoreboard holds that cell 208 is rewritten while cell 207 is not.

// File: rtl/ocd_pkg.sv
package ocd_pkg;
  typedef enum logic [1:0] {LVL_LO = 2'd0, LVL_MID = 2'd1, LVL_HI = 2'd2} lvl_e;

  localparam int unsigned PAIR_BITS = 3;
  localparam logic [3:0]  PAIR_BAD  = 4'd8;

  function automatic lvl_e sym_to_lvl(input logic [1:0] sym);
    case (sym)
      2'b11:   return LVL_LO;
      2'b00:   return LVL_HI;
      default: return LVL_MID;
    endcase
  endfunction
endpackage

// File: rtl/ocd_spare_unpack.sv
module ocd_spare_unpack
  import ocd_pkg::*;
#(
  parameter int unsigned NSPARE = 32,
  parameter int unsigned NCORR  = 48
) (
  input  logic [2*NSPARE-1:0] spare_i,
  output logic [NCORR-1:0]    corr_o,
  output logic                bad_o
);
  localparam int unsigned NPAIR = NSPARE / 2;

  logic [NPAIR-1:0] pair_bad;

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    localparam int unsigned CA = NSPARE - 1 - 2*p;
    localparam int unsigned CB = NSPARE - 2 - 2*p;
    lvl_e       dig_a, dig_b;
    logic [3:0] val;
    assign dig_a = sym_to_lvl(spare_i[2*CA +: 2]);
    assign dig_b = sym_to_lvl(spare_i[2*CB +: 2]);
    assign val   = 4'(dig_a) * 4'd3 + 4'(dig_b);
    assign pair_bad[p] = (val == PAIR_BAD);
    // lowest index takes the MSB
    assign corr_o[PAIR_BITS*p +: PAIR_BITS] = {val[0], val[1], val[2]};
  end

  assign bad_o = |pair_bad;
endmodule

// File: rtl/ocd_group_count.sv
module ocd_group_count #(
  parameter int unsigned NCELL = 256,
  parameter int unsigned GRP   = 16,
  parameter int unsigned GS_W  = 5
) (
  input  logic [NCELL-1:0]                 flag_i,
  output logic [NCELL/GRP-1:0][GS_W-1:0]   gsum_o
);
  localparam int unsigned NGRP = NCELL / GRP;

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    logic [GS_W-1:0] sum;
    always_comb begin
      sum = '0;
      for (int i = 0; i < GRP; i++) sum = sum + GS_W'(flag_i[g*GRP + i]);
    end
    assign gsum_o[g] = sum;
  end
endmodule

// File: rtl/ocd_cell_offset.sv
module ocd_cell_offset #(
  parameter int unsigned NCELL = 256,
  parameter int unsigned GRP   = 16,
  parameter int unsigned GS_W  = 5,
  parameter int unsigned OFS_W = 9
) (
  input  logic [NCELL-1:0]               flag_i,
  input  logic [NCELL/GRP-1:0][GS_W-1:0] gsum_i,
  output logic [NCELL-1:0][OFS_W-1:0]    ofs_o
);
  localparam int unsigned NGRP = NCELL / GRP;

  // group prefix from the totals, then a short walk inside each group
  always_comb begin
    logic [OFS_W-1:0] acc;
    logic [OFS_W-1:0] run;
    acc = '0;
    for (int g = NGRP - 1; g >= 0; g--) begin
      run = acc;
      for (int i = GRP - 1; i >= 0; i--) begin
        ofs_o[g*GRP + i] = run;
        run = run + OFS_W'(flag_i[g*GRP + i]);
      end
      acc = acc + OFS_W'(gsum_i[g]);
    end
  end
endmodule

// File: rtl/corr_offset_decoder.sv
module corr_offset_decoder #(
  parameter int unsigned NCELL  = 256,
  parameter int unsigned NSPARE = 32,
  parameter int unsigned GRP    = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                valid_i,
  input  logic                bypass_i,
  input  logic [2*NCELL-1:0]  line_i,
  input  logic [2*NSPARE-1:0] spare_i,
  output logic                valid_o,
  output logic                err_o,
  output logic [2*NCELL-1:0]  line_o
);
  localparam int unsigned NCORR = (NSPARE / 2) * 3;
  localparam int unsigned NGRP  = NCELL / GRP;
  localparam int unsigned GS_W  = $clog2(GRP + 1);
  localparam int unsigned OFS_W = $clog2(NCELL + 1);
  localparam int unsigned CI_W  = $clog2(NCORR);

  // stage A inputs
  logic [NCELL-1:0]             flag;
  logic [NGRP-1:0][GS_W-1:0]    gsum;
  logic [NCORR-1:0]             corr;
  logic                         bad;

  for (genvar n = 0; n < NCELL; n++) begin : g_flag
    assign flag[n] = line_i[2*n] ^ line_i[2*n + 1];
  end

  ocd_spare_unpack #(.NSPARE(NSPARE), .NCORR(NCORR)) i_unpack (
    .spare_i (spare_i),
    .corr_o  (corr),
    .bad_o   (bad)
  );

  ocd_group_count #(.NCELL(NCELL), .GRP(GRP), .GS_W(GS_W)) i_gcount (
    .flag_i (flag),
    .gsum_o (gsum)
  );

  // stage A registers
  logic                      a_valid, a_byp, a_bad;
  logic [2*NCELL-1:0]        a_line;
  logic [NCELL-1:0]          a_flag;
  logic [NGRP-1:0][GS_W-1:0] a_gsum;
  logic [NCORR-1:0]          a_corr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_valid <= 1'b0;
      a_byp   <= 1'b0;
      a_bad   <= 1'b0;
      a_line  <= '0;
      a_flag  <= '0;
      a_gsum  <= '0;
      a_corr  <= '0;
    end else begin
      a_valid <= valid_i;
      a_byp   <= bypass_i;
      a_bad   <= bad;
      a_line  <= line_i;
      a_flag  <= flag;
      a_gsum  <= gsum;
      a_corr  <= corr;
    end
  end

  // stage B: offsets and rewrite
  logic [NCELL-1:0][OFS_W-1:0] ofs;
  logic [2*NCELL-1:0]          line_fix;
  logic                        fix_en;

  ocd_cell_offset #(.NCELL(NCELL), .GRP(GRP), .GS_W(GS_W), .OFS_W(OFS_W)) i_offset (
    .flag_i (a_flag),
    .gsum_i (a_gsum),
    .ofs_o  (ofs)
  );

  assign fix_en = ~a_byp & ~a_bad;

  always_comb begin
    line_fix = a_line;
    for (int n = 0; n < NCELL; n++) begin
      if (fix_en && a_flag[n] && (ofs[n] < OFS_W'(NCORR)))
        line_fix[2*n +: 2] = a_corr[ofs[n][CI_W-1:0]] ? 2'b10 : 2'b01;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      err_o   <= 1'b0;
      line_o  <= '0;
    end else begin
      valid_o <= a_valid;
      err_o   <= a_valid & a_bad & ~a_byp;
      line_o  <= line_fix;
    end
  end
endmodule

// File: rtl/ocd_checker.sv
module ocd_checker #(
  parameter int unsigned NCELL = 256
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               valid_i,
  input logic               bypass_i,
  input logic [2*NCELL-1:0] line_i,
  input logic               valid_o,
  input logic               err_o,
  input logic [2*NCELL-1:0] line_o
);
  logic               vld_d1, vld_d2, byp_d1, byp_d2;
  logic [2*NCELL-1:0] line_d1, line_d2;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_d1 <= 1'b0; vld_d2 <= 1'b0;
      byp_d1 <= 1'b0; byp_d2 <= 1'b0;
      line_d1 <= '0;  line_d2 <= '0;
    end else begin
      vld_d1 <= valid_i;  vld_d2 <= vld_d1;
      byp_d1 <= bypass_i; byp_d2 <= byp_d1;
      line_d1 <= line_i;  line_d2 <= line_d1;
    end
  end

  a_r1_valid_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == vld_d2);

  a_r9_err_only_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> valid_o);

  a_r6_err_passthru: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> line_o == line_d2);

  a_r7_bypass_passthru: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && byp_d2) |-> (line_o == line_d2 && !err_o));

  for (genvar n = 0; n < NCELL; n++) begin : g_cell
    a_r2_edge_cell_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_o && !(line_d2[2*n] ^ line_d2[2*n+1])) |-> line_o[2*n +: 2] == line_d2[2*n +: 2]);
    a_r3_mid_stays_mid: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_o && (line_d2[2*n] ^ line_d2[2*n+1])) |-> (line_o[2*n] ^ line_o[2*n+1]));
  end
endmodule

bind corr_offset_decoder ocd_checker #(.NCELL(NCELL)) i_ocd_checker (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .valid_i  (valid_i),
  .bypass_i (bypass_i),
  .line_i   (line_i),
  .valid_o  (valid_o),
  .err_o    (err_o),
  .line_o   (line_o)
);

// File: tb/test_corr_offset_decoder.sv
`timescale 1ns/1ps
module test_corr_offset_decoder;
  localparam int NCELL  = 256;
  localparam int NSPARE = 32;
  localparam int NCORR  = 48;
  localparam int LW     = 2*NCELL;
  localparam int SW     = 2*NSPARE;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          valid_i = 1'b0;
  logic          bypass_i = 1'b0;
  logic [LW-1:0] line_i = '0;
  logic [SW-1:0] spare_i = '0;
  logic          valid_o, err_o;
  logic [LW-1:0] line_o;

  int n_tests = 0;
  int n_fail  = 0;

  typedef struct {
    logic [LW-1:0] line;
    logic          err;
    string         tag;
  } exp_t;
  exp_t sb[$];

  always #4 clk_i = ~clk_i;

  corr_offset_decoder i_corr_offset_decoder (
    .clk_i, .rst_ni, .valid_i, .bypass_i, .line_i, .spare_i,
    .valid_o, .err_o, .line_o
  );

  function automatic int lvl(input logic [1:0] s);
    if (s == 2'b11) return 0;
    if (s == 2'b00) return 2;
    return 1;
  endfunction

  function automatic logic [1:0] sym(input int d);
    if (d == 0) return 2'b11;
    if (d == 2) return 2'b00;
    return ($urandom_range(0, 1) != 0) ? 2'b01 : 2'b10;
  endfunction

  // R5 encoding: pair p -> cells 31-2p, 30-2p; bit 3p is MSB
  function automatic logic [SW-1:0] enc_spare(input logic [NCORR-1:0] cb);
    logic [SW-1:0] sp;
    sp = '0;
    for (int p = 0; p < NSPARE/2; p++) begin
      int v;
      v = 4*int'(cb[3*p]) + 2*int'(cb[3*p+1]) + int'(cb[3*p+2]);
      sp[2*(31-2*p) +: 2] = sym(v / 3);
      sp[2*(30-2*p) +: 2] = sym(v % 3);
    end
    return sp;
  endfunction

  function automatic void model(input logic [LW-1:0] ln, input logic [SW-1:0] sp,
                                input logic byp, output logic [LW-1:0] o, output logic e);
    logic [NCORR-1:0] cb;
    bit bad;
    int cnt;
    bad = 0;
    cb  = '0;
    for (int p = 0; p < NSPARE/2; p++) begin
      int v;
      v = 3*lvl(sp[2*(31-2*p) +: 2]) + lvl(sp[2*(30-2*p) +: 2]);
      if (v == 8) bad = 1;
      cb[3*p]   = v[2];
      cb[3*p+1] = v[1];
      cb[3*p+2] = v[0];
    end
    o = ln;
    e = bad && !byp;
    if (!byp && !bad) begin
      cnt = 0;
      for (int n = NCELL-1; n >= 0; n--) begin
        if (ln[2*n] ^ ln[2*n+1]) begin
          if (cnt < NCORR) o[2*n +: 2] = cb[cnt] ? 2'b10 : 2'b01;
          cnt++;
        end
      end
    end
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [LW-1:0] act, input logic [LW-1:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic send(input logic [LW-1:0] ln, input logic [SW-1:0] sp,
                      input logic byp, input string tag);
    exp_t x;
    model(ln, sp, byp, x.line, x.err);
    x.tag = tag;
    sb.push_back(x);
    valid_i  = 1'b1;
    bypass_i = byp;
    line_i   = ln;
    spare_i  = sp;
    @(negedge clk_i);
    valid_i  = 1'b0;
  endtask

  // monitor
  always @(negedge clk_i) begin
    if (rst_ni && valid_o) begin
      if (sb.size() == 0) begin
        check(1'b0, "R9", "unexpected valid_o", LW'(1), LW'(0));
      end else begin
        exp_t x;
        x = sb.pop_front();
        check(line_o == x.line, x.tag, "line_o", line_o, x.line);
        check(err_o == x.err, x.tag, "err_o", LW'(err_o), LW'(x.err));
      end
    end
  end

  function automatic logic [LW-1:0] rand_line(input int mode);
    logic [LW-1:0] l;
    for (int n = 0; n < NCELL; n++) begin
      int r;
      r = $urandom_range(0, 3);
      if (mode == 1 && (r == 1 || r == 2)) r = 0;
      l[2*n +: 2] = 2'(r);
    end
    return l;
  endfunction

  function automatic logic [NCORR-1:0] rand_cb();
    return {$urandom(), $urandom()} & {NCORR{1'b1}};
  endfunction

  initial begin
    repeat (100000) @(posedge clk_i);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [LW-1:0] l;
    logic [SW-1:0] sp;
    repeat (3) @(negedge clk_i);
    check(valid_o == 1'b0 && err_o == 1'b0, "R1", "reset outputs",
          LW'({valid_o, err_o}), LW'(0));
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 latency: one line, then watch valid_o edge by edge
    send({NCELL{2'b01}}, enc_spare(rand_cb()), 1'b0, "R1");
    check(valid_o == 1'b0, "R1", "valid_o one edge after", LW'(valid_o), LW'(0));
    @(negedge clk_i);
    check(valid_o == 1'b1, "R1", "valid_o two edges after", LW'(valid_o), LW'(1));
    @(negedge clk_i);
    check(valid_o == 1'b0, "R9", "valid_o after idle", LW'(valid_o), LW'(0));

    // R2 edge-level cells only
    send({NCELL{2'b00}}, enc_spare(rand_cb()), 1'b0, "R2");
    send({NCELL{2'b11}}, enc_spare(rand_cb()), 1'b0, "R2");
    send(rand_line(1), enc_spare(rand_cb()), 1'b0, "R2");

    // R5 directed: single middle cell at 255
    l = {NCELL{2'b00}};
    l[2*255 +: 2] = 2'b01;
    send(l, enc_spare(48'h000000000001), 1'b0, "R5");  // cb[0]=1 -> 10
    send(l, enc_spare(48'h0), 1'b0, "R5");             // cb[0]=0 -> 01
    // R5: both middle symbols give level 1, pair L1L1 = 100
    send({NCELL{2'b10}}, {NSPARE{2'b01}}, 1'b0, "R5");
    send({NCELL{2'b10}}, {NSPARE{2'b10}}, 1'b0, "R5");

    // R4 boundary: all middle cells, offsets 47/48 at cells 208/207
    send({NCELL{2'b01}}, enc_spare(rand_cb()), 1'b0, "R4");
    send({NCELL{2'b10}}, enc_spare(48'hFFFFFFFFFFFF), 1'b0, "R4");

    // R6 invalid pair, then R7 together with it
    sp = enc_spare(rand_cb());
    sp[2*(31-10) +: 2] = 2'b00;
    sp[2*(30-10) +: 2] = 2'b00;
    l = rand_line(0);
    send(l, sp, 1'b0, "R6");
    send(l, sp, 1'b1, "R7");
    send(l, sp, 1'b0, "R6");
    send(rand_line(0), enc_spare(rand_cb()), 1'b1, "R7");

    // R3 / R8 back-to-back random lines, mixed bypass
    for (int k = 0; k < 60; k++) begin
      send(rand_line(0), enc_spare(rand_cb()), 1'(k % 7 == 3), "R3");
    end
    for (int k = 0; k < 40; k++) begin
      sp = enc_spare(rand_cb());
      if (k % 5 == 0) begin
        sp[2*(31-2*(k%16)) +: 2] = 2'b00;
        sp[2*(30-2*(k%16)) +: 2] = 2'b00;
      end
      send(rand_line(0), sp, 1'b0, "R8");
    end

    repeat (4) @(negedge clk_i);
    check(valid_o == 1'b0 && err_o == 1'b0, "R9", "idle outputs",
          LW'({valid_o, err_o}), LW'(0));
    check(sb.size() == 0, "R8", "all lines returned", LW'(sb.size()), LW'(0));
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule